// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Sequencer

This block sits in the command path of a DDR3-class memory controller. It moves the memory into its low-power self-refresh state and back out again. It asks for one entry request and one exit request from the host. The block then issues the needed commands and applies every minimum spacing between them, so the command scheduler only has to watch two permission outputs.

On an entry request the block withdraws all permissions and disables termination. It then waits until no burst is in flight. If any bank is still open it closes all banks with a single precharge-all and lets the precharge time run out. When termination is enabled in the mode registers, it also allows the termination-off time. It then issues the self-refresh entry command with the clock enable low and keeps the clock enable low. On an exit request it first waits out the minimum low time of the clock enable. If the host said the clock would be stopped or retuned, it also waits a stable-clock interval. It then raises the clock enable and sends only no-operation cycles for the exit window. Next it issues a long calibration. Commands that need no locked DLL are allowed from that point. Full traffic is allowed only after the calibration time and the DLL relock time have both run out. A separate write permission also waits for the reference voltage to be valid for a programmed number of cycles.

All intervals are parameters counted in controller clock cycles by loadable down-counters, and each parameter must be at least 1.

Top module: `srf_sequencer`

## Requirements
- R1: After reset: cke=1, cmd=0 (no-op), odt_allow=1, ready_no_dll=1, ready_full=1, write_ok=1, busy=0, sr_active=0, clk_change_ok=0.
- R2: If enter_req is high in a cycle while ready_full is high, then in the next cycle busy=1 and ready_full, ready_no_dll and odt_allow are 0. No command other than no-op goes out while burst_busy is high.
- R3: Let d be the first cycle after acceptance in which burst_busy is low. If banks_open is high, exactly one precharge-all (cmd=1) goes out in cycle d+1 and the entry command follows PRE_WAIT+1 cycles later. If banks_open is low, no precharge-all goes out.
- R4: The entry command (cmd=2) goes out ODT_WAIT cycles later than R3 gives when odt_needed is high, and at once when it is low. odt_allow stays 0 whenever cke is 0.
- R5: In the entry-command cycle cke=0. cke stays 0, with sr_active=1, until the exit step of R6 raises it.
- R6: Let s be the entry cycle and e the first cycle after s in which exit_req is high. cke rises in cycle max(s+MIN_LOW+1, e+1). CLK_ON_WAIT more cycles are added when clk_alter was high at acceptance.
- R7: clk_change_ok rises in cycle s+CLK_OFF_WAIT+1 if clk_alter was high at acceptance and the block is still resting in self-refresh. It falls when exit starts, and it never rises otherwise.
- R8: Let r be the cycle in which cke rises. Cycles r to r+EXIT_WAIT-1 carry only no-ops, with ready_no_dll=0. A long calibration (cmd=3) goes out in cycle r+EXIT_WAIT, and ready_no_dll rises in cycle r+EXIT_WAIT+1.
- R9: ready_full, odt_allow and busy=0 return in cycle max(r+EXIT_WAIT+CAL_WAIT+1, r+LOCK_WAIT).
- R10: After an entry command, write_ok equals ready_full AND (vref_ok was high in each of the last VREF_WAIT cycles after the entry cycle). A low vref_ok restarts the wait until that wait has completed once.
- R11: enter_req is ignored unless ready_full is high, and exit_req is ignored except while resting in self-refresh. An ignored request changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | Request to enter self-refresh |
| exit_req | input | 1 | Request to leave self-refresh |
| banks_open | input | 1 | At least one bank is active |
| burst_busy | input | 1 | A read or write burst is in flight |
| odt_needed | input | 1 | Nominal or write termination is enabled |
| clk_alter | input | 1 | Clock will be stopped or retuned during self-refresh |
| vref_ok | input | 1 | Data reference voltage is valid |
| cmd | output | 3 | Command code: 0 no-op, 1 precharge-all, 2 self-refresh entry, 3 long calibration |
| cke | output | 1 | Clock enable to the memory |
| odt_allow | output | 1 | Termination may be driven |
| sr_active | output | 1 | Clock enable is held low |
| busy | output | 1 | Entry or exit sequence in progress |
| ready_no_dll | output | 1 | Commands that need no locked DLL may be issued |
| ready_full | output | 1 | All commands may be issued |
| write_ok | output | 1 | Writes may be issued |
| clk_change_ok | output | 1 | Clock may now be stopped or retuned |

## Verification
The assertions assume two things about the host. burst_busy does not rise again once the block has accepted an entry request. banks_open, odt_needed and clk_alter stay steady from acceptance until the entry command. The stimulus meets these by setting those inputs before each request and holding them until ready_full returns. It ends a burst only by lowering burst_busy. exit_req is pulsed only after the entry command has been seen. vref_ok is the one input left free to toggle at random throughout.

// File: rtl/srf_pkg.sv
`timescale 1ns/1ps
package srf_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP  = 3'd0,
    CMD_PREA = 3'd1,
    CMD_SRE  = 3'd2,
    CMD_ZQCL = 3'd3
  } srf_cmd_e;

  typedef enum logic [3:0] {
    ST_NORM, ST_DRAIN, ST_PRE, ST_WRP, ST_ODTW, ST_SRE,
    ST_SR, ST_CKSRX, ST_XS, ST_ZQC, ST_ZQW, ST_FIN
  } srf_state_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // a wait of N cycles loaded with N ends in the cycle where the count is 1
  function automatic logic last_cycle(int unsigned c);
    return c <= 1;
  endfunction

  function automatic int unsigned cnt_width(int unsigned maxv);
    return $clog2(maxv + 1);
  endfunction
endpackage

// File: rtl/srf_timer.sv
`timescale 1ns/1ps
module srf_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/srf_fsm.sv
`timescale 1ns/1ps
module srf_fsm
  import srf_pkg::*;
#(
  parameter int unsigned CW         = 10,
  parameter int unsigned PRE_WAIT   = 6,
  parameter int unsigned ODT_WAIT   = 4,
  parameter int unsigned MIN_LOW    = 5,
  parameter int unsigned CLK_ON_WAIT = 5,
  parameter int unsigned EXIT_WAIT  = 24,
  parameter int unsigned CAL_WAIT   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter_req,
  input  logic          exit_req,
  input  logic          banks_open,
  input  logic          burst_busy,
  input  logic          odt_needed,
  input  logic          clk_alter,
  input  logic [CW-1:0] main_cnt,
  input  logic [CW-1:0] lock_cnt,
  output srf_state_e    st,
  output logic          main_load,
  output logic [CW-1:0] main_val,
  output logic          lock_load,
  output logic          alt_q,
  output logic          cke,
  output srf_cmd_e      cmd
);
  srf_state_e nxt;
  logic pend_q;
  logic main_end, lock_end, accept, leave_go;

  assign main_end = last_cycle(32'(main_cnt));
  assign lock_end = last_cycle(32'(lock_cnt));
  assign accept   = (st == ST_NORM) && enter_req;
  assign leave_go = (st == ST_SR) && (exit_req || pend_q) && main_end;

  function automatic logic [CW-1:0] dur(srf_state_e s);
    case (s)
      ST_WRP:   return CW'(PRE_WAIT);
      ST_ODTW:  return CW'(ODT_WAIT);
      ST_SR:    return CW'(MIN_LOW);
      ST_CKSRX: return CW'(CLK_ON_WAIT);
      ST_XS:    return CW'(EXIT_WAIT);
      ST_ZQW:   return CW'(CAL_WAIT);
      default:  return '0;
    endcase
  endfunction

  always_comb begin
    nxt = st;
    case (st)
      ST_NORM:  if (accept) nxt = ST_DRAIN;
      ST_DRAIN: if (!burst_busy)
                  nxt = banks_open ? ST_PRE : (odt_needed ? ST_ODTW : ST_SRE);
      ST_PRE:   nxt = ST_WRP;
      ST_WRP:   if (main_end) nxt = odt_needed ? ST_ODTW : ST_SRE;
      ST_ODTW:  if (main_end) nxt = ST_SRE;
      ST_SRE:   nxt = ST_SR;
      ST_SR:    if (leave_go) nxt = alt_q ? ST_CKSRX : ST_XS;
      ST_CKSRX: if (main_end) nxt = ST_XS;
      ST_XS:    if (main_end) nxt = ST_ZQC;
      ST_ZQC:   nxt = ST_ZQW;
      ST_ZQW:   if (main_end) nxt = lock_end ? ST_NORM : ST_FIN;
      ST_FIN:   if (lock_end) nxt = ST_NORM;
      default:  nxt = ST_NORM;
    endcase
  end

  assign main_load = (nxt != st);
  assign main_val  = dur(nxt);
  assign lock_load = (nxt == ST_XS) && (st != ST_XS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_NORM;
      pend_q <= 1'b0;
      alt_q  <= 1'b0;
    end else begin
      st     <= nxt;
      pend_q <= (st == ST_SR) ? ((pend_q | exit_req) & ~leave_go) : 1'b0;
      if (accept) alt_q <= clk_alter;
    end
  end

  always_comb begin
    case (st)
      ST_PRE:  cmd = CMD_PREA;
      ST_SRE:  cmd = CMD_SRE;
      ST_ZQC:  cmd = CMD_ZQCL;
      default: cmd = CMD_NOP;
    endcase
  end
  assign cke = !(st == ST_SRE || st == ST_SR || st == ST_CKSRX);

  // checker counters, separate from the sequencing logic
  logic [CW:0] low_cnt, since_pre;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      since_pre <= '1;
    end else begin
      low_cnt   <= cke ? '0 : ((low_cnt == '1) ? low_cnt : low_cnt + 1'b1);
      since_pre <= (cmd == CMD_PREA) ? '0 :
                   ((since_pre == '1) ? since_pre : since_pre + 1'b1);
    end
  end

  // R5
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_SRE) || (st == ST_SR && !leave_go)) |=> !cke);
  // R6
  min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (32'(low_cnt) > MIN_LOW));
  // R3
  sre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_SRE) |-> (32'(since_pre) >= PRE_WAIT));
endmodule

// File: rtl/srf_sequencer.sv
`timescale 1ns/1ps
module srf_sequencer
  import srf_pkg::*;
#(
  parameter int unsigned PRE_WAIT     = 6,
  parameter int unsigned ODT_WAIT     = 4,
  parameter int unsigned MIN_LOW      = 5,
  parameter int unsigned CLK_OFF_WAIT = 5,
  parameter int unsigned CLK_ON_WAIT  = 5,
  parameter int unsigned EXIT_WAIT    = 24,
  parameter int unsigned CAL_WAIT     = 32,
  parameter int unsigned LOCK_WAIT    = 96,
  parameter int unsigned VREF_WAIT    = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter_req,
  input  logic             exit_req,
  input  logic             banks_open,
  input  logic             burst_busy,
  input  logic             odt_needed,
  input  logic             clk_alter,
  input  logic             vref_ok,
  output logic [CMD_W-1:0] cmd,
  output logic             cke,
  output logic             odt_allow,
  output logic             sr_active,
  output logic             busy,
  output logic             ready_no_dll,
  output logic             ready_full,
  output logic             write_ok,
  output logic             clk_change_ok
);
  localparam int unsigned MAXV = max2(max2(max2(PRE_WAIT, ODT_WAIT), max2(MIN_LOW, CLK_OFF_WAIT)),
                                      max2(max2(CLK_ON_WAIT, EXIT_WAIT),
                                           max2(CAL_WAIT, max2(LOCK_WAIT, VREF_WAIT))));
  localparam int unsigned CW = cnt_width(MAXV);

  srf_state_e    st;
  srf_cmd_e      cmd_i;
  logic          main_load, lock_load, alt_q, cke_i;
  logic [CW-1:0] main_val, main_cnt, lock_cnt, off_cnt, vref_cnt;
  logic          sre_evt, vref_load, vref_done;

  srf_fsm #(
    .CW(CW), .PRE_WAIT(PRE_WAIT), .ODT_WAIT(ODT_WAIT), .MIN_LOW(MIN_LOW),
    .CLK_ON_WAIT(CLK_ON_WAIT), .EXIT_WAIT(EXIT_WAIT), .CAL_WAIT(CAL_WAIT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
    .banks_open(banks_open), .burst_busy(burst_busy), .odt_needed(odt_needed),
    .clk_alter(clk_alter), .main_cnt(main_cnt), .lock_cnt(lock_cnt),
    .st(st), .main_load(main_load), .main_val(main_val), .lock_load(lock_load),
    .alt_q(alt_q), .cke(cke_i), .cmd(cmd_i)
  );

  assign sre_evt   = (cmd_i == CMD_SRE);
  assign vref_load = sre_evt || (!vref_ok && vref_cnt != '0);
  assign vref_done = (vref_cnt == '0);

  srf_timer #(.W(CW)) u_main (.clk(clk), .rst_n(rst_n), .load(main_load), .dec(1'b1),
                              .load_val(main_val), .cnt(main_cnt));
  srf_timer #(.W(CW)) u_lock (.clk(clk), .rst_n(rst_n), .load(lock_load), .dec(1'b1),
                              .load_val(CW'(LOCK_WAIT)), .cnt(lock_cnt));
  srf_timer #(.W(CW)) u_off  (.clk(clk), .rst_n(rst_n), .load(sre_evt), .dec(1'b1),
                              .load_val(CW'(CLK_OFF_WAIT)), .cnt(off_cnt));
  srf_timer #(.W(CW)) u_vref (.clk(clk), .rst_n(rst_n), .load(vref_load), .dec(vref_ok),
                              .load_val(CW'(VREF_WAIT)), .cnt(vref_cnt));

  assign cmd           = cmd_i;
  assign cke           = cke_i;
  assign sr_active     = !cke_i;
  assign ready_full    = (st == ST_NORM);
  assign ready_no_dll  = (st == ST_NORM) || (st == ST_ZQW) || (st == ST_FIN);
  assign odt_allow     = ready_full;
  assign busy          = !(st == ST_NORM || st == ST_SR);
  assign write_ok      = ready_full && vref_done;
  assign clk_change_ok = (st == ST_SR) && alt_q && (off_cnt == '0);

  logic zq_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)                  zq_seen <= 1'b0;
    else if (cmd_i == CMD_ZQCL)  zq_seen <= 1'b1;
    else if (sre_evt)            zq_seen <= 1'b0;
  end

  // R4
  odt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> !odt_allow);
  // R8
  zq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_full) |-> zq_seen);
  // R9
  ready_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_full |-> ready_no_dll);
endmodule

// File: tb/tb_srf_sequencer.sv
`timescale 1ns/1ps
module tb_srf_sequencer;
  localparam int PW = 6, OW = 4, ML = 5, CO = 5, CN = 5, XW = 24, ZW = 32, LW = 96, VW = 512;

  logic clk = 0, rst_n = 0;
  logic enter_req = 0, exit_req = 0, banks_open = 0, burst_busy = 0;
  logic odt_needed = 0, clk_alter = 0, vref_ok = 1;
  logic [2:0] cmd;
  logic cke, odt_allow, sr_active, busy, ready_no_dll, ready_full, write_ok, clk_change_ok;

  srf_sequencer #(.PRE_WAIT(PW), .ODT_WAIT(OW), .MIN_LOW(ML), .CLK_OFF_WAIT(CO),
    .CLK_ON_WAIT(CN), .EXIT_WAIT(XW), .CAL_WAIT(ZW), .LOCK_WAIT(LW), .VREF_WAIT(VW)) dut (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
    .banks_open(banks_open), .burst_busy(burst_busy), .odt_needed(odt_needed),
    .clk_alter(clk_alter), .vref_ok(vref_ok), .cmd(cmd), .cke(cke), .odt_allow(odt_allow),
    .sr_active(sr_active), .busy(busy), .ready_no_dll(ready_no_dll), .ready_full(ready_full),
    .write_ok(write_ok), .clk_change_ok(clk_change_ok));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, vm = 0, vref_mode = 0;
  int prea_c = -1, sre_c = -1, zq_c = -1, r_c = -1, rnd_c = -1, rf_c = -1, cko_c = -1;
  int err5 = 0, err8 = 0, err10 = 0;
  logic p_cke = 1, p_rnd = 1, p_rf = 1, p_cko = 0;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  // cycle counter, watchdog, write permission model (R10)
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) vm <= 0;
    else if (cmd == 3'd2) vm <= VW;
    else if (vm != 0) vm <= vref_ok ? vm - 1 : VW;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      summary();
      $finish;
    end
  end

  // event monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd == 3'd1) prea_c = cyc;
      if (cmd == 3'd2) begin sre_c = cyc; if (cke) err5++; end
      if (cmd == 3'd3) zq_c = cyc;
      if (cke && !p_cke) r_c = cyc;
      if (ready_no_dll && !p_rnd) rnd_c = cyc;
      if (ready_full && !p_rf) rf_c = cyc;
      if (clk_change_ok && !p_cko) cko_c = cyc;
      if (sr_active == cke) err5++;
      if (r_c >= 0 && cyc >= r_c && cyc < r_c + XW && (cmd != 3'd0 || ready_no_dll)) err8++;
      if (write_ok != (ready_full && vm == 0)) err10++;
      p_cke = cke; p_rnd = ready_no_dll; p_rf = ready_full; p_cko = clk_change_ok;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      vref_ok = (vref_mode != 0) ? (($urandom % 40) != 0) : 1'b1;
    end
  end

  task automatic run_seq(bit bo, bit on, bit alt, int bl, int ed, bit poke);
    int c0, d, s, e, r, wt, base, pre_exp, r_exp, rf_exp, cko_exp, e5, e8, e10;
    e5 = err5; e8 = err8; e10 = err10;
    banks_open = bo; odt_needed = on; clk_alter = alt; burst_busy = (bl > 0);
    step();
    c0 = cyc; enter_req = 1;
    step();
    enter_req = 0;
    chk("R2 busy after accept", busy, 1);
    chk("R2 ready_full dropped", ready_full, 0);
    chk("R2 ready_no_dll dropped", ready_no_dll, 0);
    chk("R2 odt_allow dropped", odt_allow, 0);
    if (bl > 0) begin
      while (cyc < c0 + bl) step();
      burst_busy = 0;
    end
    d = imax(c0 + 1, c0 + bl);
    wt = 0;
    while (sre_c <= c0 && wt < 5000) begin step(); wt++; end
    s = sre_c;
    pre_exp = d + 1;
    base = bo ? (d + PW + 2) : (d + 1);
    chk("R3 precharge-all cycle", (prea_c > c0) ? prea_c - c0 : -1, bo ? pre_exp - c0 : -1);
    chk("R4 entry command cycle", s - c0, base + (on ? OW : 0) - c0);
    if (poke) begin
      while (cyc < s + 1) step();
      enter_req = 1; step(); enter_req = 0;
    end
    e = s + ed;
    while (cyc < e) step();
    if (cyc > e) e = cyc;
    chk("R11 enter_req ignored in self-refresh", {cke, busy}, 2'b00);
    exit_req = 1; step(); exit_req = 0;
    r_exp = imax(s + ML + 1, e + 1) + (alt ? CN : 0);
    cko_exp = (alt && imax(s + ML, e) >= s + CO + 1) ? CO + 1 : -1;
    wt = 0;
    while (rf_c <= s && wt < 5000) begin
      enter_req = (poke && r_c > s && cyc == r_c + 1);
      step(); wt++;
    end
    enter_req = 0;
    r = r_c;
    rf_exp = imax(r + XW + ZW + 1, r + LW);
    chk("R6 clock enable rise", r - s, r_exp - s);
    chk("R7 clock change permission", (cko_c > s) ? cko_c - s : -1, cko_exp);
    chk("R8 calibration cycle", zq_c - r, XW);
    chk("R8 ready_no_dll rise", rnd_c - r, XW + 1);
    chk("R8 no-op window", err8 - e8, 0);
    chk("R9 ready_full rise", rf_c - r, rf_exp - r);
    chk("R5 clock enable held low", err5 - e5, 0);
    chk("R10 write permission", err10 - e10, 0);
    if (poke) begin
      step(); step(); step();
      chk("R11 enter_req ignored during exit", {busy, cke, ready_full}, 3'b011);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    #1;
    chk("R1 cke", cke, 1);
    chk("R1 cmd", cmd, 0);
    chk("R1 permissions", {ready_no_dll, ready_full, write_ok, odt_allow}, 4'hF);
    chk("R1 status", {busy, sr_active, clk_change_ok}, 3'b000);
    rst_n = 1;
    step(); step();
    exit_req = 1; step(); exit_req = 0; step(); step();
    chk("R11 exit_req ignored in normal", {cke, busy, sr_active, ready_full}, 4'b1001);
    chk("R11 exit_req no command", cmd, 0);
    run_seq(1, 1, 0, 0, 2, 0);
    run_seq(0, 0, 1, 3, 10, 0);
    run_seq(1, 0, 1, 2, 1, 0);
    run_seq(0, 1, 0, 1, 7, 1);
    for (int i = 0; i < 8; i++) begin
      vref_mode = $urandom % 2;
      run_seq(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
              int'($urandom % 5), 1 + int'($urandom % 12), 1'($urandom % 2));
    end
    vref_mode = 0;
    repeat (VW + 20) step();
    chk("R10 write_ok after steady reference", write_ok, 1);
    summary();
    $finish;
  end
endmodule